// File: doc/BRIEF.md
# Horizontal Blanking Counter and Level Replacer

This block sits on a multi-channel video datapath and does two jobs around horizontal blanking. First, it keeps a free-running line counter that restarts whenever the registered blanking control goes from high to low. A set of comparators watches that counter and raises sticky flags when it reaches programmable terminal counts. Typical uses are marking the start of active video, or a fixed position inside a line, relative to the end of blanking.

Second, while the registered blanking control is high, every data channel is overwritten with a per-channel constant level. Blanked and live samples leave through the same two-register path, so the substitution lines up exactly with the data it replaces. The blanking levels and terminal counts are written through one simple address/data write port. A registered active-low clear input empties all flags one edge after it is sampled low.

Top module: `blank_level_unit`

## Requirements
- R1: While `arst_n` is low, and right after it is released, `dout` is all zeros and `flags` is all zeros.
- R2: A low level on `hblank` that is sampled at edge k, with a high level sampled at edge k-1, restarts the counter to 0 at edge k+1. The counter then rises by one per edge, so flag i goes high after edge k+2+T, where T is the terminal count of flag i.
- R3: Each flag has its own terminal count and sets independently of the others. All flags share the one counter.
- R4: Once set, a flag stays high until a blanking falling edge (R5) or a clear (R6) removes it.
- R5: The restart edge k+1 of R2 also drives every flag to 0. Clearing takes priority over setting.
- R6: When `clr_n` is sampled low at edge k, every flag is 0 after edge k+1. Clearing takes priority over setting.
- R7: The counter saturates at 2^CNT_W-1 and does not wrap. A flag whose terminal count is that maximum sets again one edge after being cleared while the counter is still saturated.
- R8: When `hblank` is sampled high at edge k, channel c of `dout` after edge k+1 equals the blanking level of channel c as it stood before edge k+1. Channel c occupies bits [c*DATA_W +: DATA_W].
- R9: When `hblank` is sampled low at edge k, channel c of `dout` after edge k+1 equals channel c of `din` as sampled at edge k. This is the same two-edge latency as R8.
- R10: A write with `wr_en` high at an edge uses this map. Address c below NUM_CH loads the blanking level of channel c from `wr_data[DATA_W-1:0]`. Address NUM_CH+i loads the terminal count of flag i from `wr_data[CNT_W-1:0]`. Every other address is ignored. The new value is in force from the following edge.
- R11: After reset every blanking level is 0 and every terminal count is 2^CNT_W-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| arst_n | input | 1 | Asynchronous active-low block reset |
| clr_n | input | 1 | Registered active-low flag clear |
| hblank | input | 1 | Horizontal blanking control, active high |
| din | input | NUM_CH*DATA_W | Input samples, channel c at [c*DATA_W +: DATA_W] |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | WR_W | Register write data |
| dout | output | NUM_CH*DATA_W | Output samples, blanked or live |
| flags | output | NUM_FLAGS | Sticky terminal-count flags |

## Verification
The bench builds the block with four 13-bit channels, two flags and an 8-bit counter instead of the 20-bit default. The narrow counter brings saturation, and re-setting a flag whose terminal count is the maximum, within a few hundred cycles. The 13-bit channels with four distinct levels exercise every bit of the replacement path. Two flags at different counts show that the flags set independently from the shared counter. An unmapped write address sits just above the terminal-count registers, so an ignored write can be told apart from a real one.

// File: rtl/blank_pkg.sv
package blank_pkg;

   // Larger of two widths; used to size the shared write data bus.
   function automatic int unsigned width_max(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

   // Address width needed to cover a given number of registers.
   function automatic int unsigned addr_bits(input int unsigned n_regs);
      return (n_regs <= 1) ? 1 : $clog2(n_regs);
   endfunction

   // Registered control view produced by the sampler stage.
   typedef struct packed {
      logic blank;     // registered blanking level
      logic restart;   // registered high-to-low transition of blanking
      logic clr;       // registered clear request (active high)
   } blank_ctl_t;

endpackage

// File: rtl/blank_sampler.sv
module blank_sampler (
   input  logic                   clk,
   input  logic                   arst_n,
   input  logic                   hblank,
   input  logic                   clr_n,
   output blank_pkg::blank_ctl_t  ctl
);
   logic hb_q;
   logic hb_prev;
   logic clr_n_q;

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         hb_q    <= 1'b0;
         hb_prev <= 1'b0;
         clr_n_q <= 1'b1;
      end else begin
         hb_q    <= hblank;
         hb_prev <= hb_q;
         clr_n_q <= clr_n;
      end
   end

   always_comb begin
      ctl.blank   = hb_q;
      ctl.restart = hb_prev & ~hb_q;
      ctl.clr     = ~clr_n_q;
   end
endmodule

// File: rtl/blank_regs.sv
module blank_regs #(
   parameter int unsigned NUM_CH    = 4,
   parameter int unsigned DATA_W    = 13,
   parameter int unsigned NUM_FLAGS = 2,
   parameter int unsigned CNT_W     = 20,
   parameter int unsigned ADDR_W    = 3,
   parameter int unsigned WR_W      = 20
) (
   input  logic                        clk,
   input  logic                        arst_n,
   input  logic                        wr_en,
   input  logic [ADDR_W-1:0]           wr_addr,
   input  logic [WR_W-1:0]             wr_data,
   output logic [NUM_CH*DATA_W-1:0]    levels,
   output logic [NUM_FLAGS*CNT_W-1:0]  limits
);
   localparam int unsigned TC_BASE = NUM_CH;
   localparam logic [CNT_W-1:0] TC_RESET = {CNT_W{1'b1}};

   if (WR_W < DATA_W) begin : g_bad_wr_data
      $error("blank_regs: WR_W must cover DATA_W");
   end
   if (WR_W < CNT_W) begin : g_bad_wr_cnt
      $error("blank_regs: WR_W must cover CNT_W");
   end
   if ((1 << ADDR_W) < (NUM_CH + NUM_FLAGS)) begin : g_bad_addr
      $error("blank_regs: ADDR_W too small for the register map");
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_level
      logic [DATA_W-1:0] level_q;
      logic              hit;
      assign hit = wr_en && (int'(wr_addr) == c);
      always_ff @(posedge clk or negedge arst_n) begin
         if (!arst_n)  level_q <= '0;
         else if (hit) level_q <= wr_data[DATA_W-1:0];
      end
      assign levels[c*DATA_W +: DATA_W] = level_q;
   end

   for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_limit
      logic [CNT_W-1:0] limit_q;
      logic             hit;
      assign hit = wr_en && (int'(wr_addr) == int'(TC_BASE) + i);
      always_ff @(posedge clk or negedge arst_n) begin
         if (!arst_n)  limit_q <= TC_RESET;
         else if (hit) limit_q <= wr_data[CNT_W-1:0];
      end
      assign limits[i*CNT_W +: CNT_W] = limit_q;
   end
endmodule

// File: rtl/blank_counter.sv
module blank_counter #(
   parameter int unsigned CNT_W     = 20,
   parameter int unsigned NUM_FLAGS = 2
) (
   input  logic                        clk,
   input  logic                        arst_n,
   input  blank_pkg::blank_ctl_t       ctl,
   input  logic [NUM_FLAGS*CNT_W-1:0]  limits,
   output logic [CNT_W-1:0]            count,
   output logic [NUM_FLAGS-1:0]        flags
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   if (CNT_W < 2) begin : g_bad_cnt
      $error("blank_counter: CNT_W must be at least 2");
   end
   if (NUM_FLAGS < 1) begin : g_bad_flags
      $error("blank_counter: NUM_FLAGS must be at least 1");
   end

   logic [CNT_W-1:0] count_q;
   logic             at_max;

   assign at_max = (count_q == CNT_MAX);

   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n)          count_q <= '0;
      else if (ctl.restart) count_q <= '0;
      else if (!at_max)     count_q <= count_q + 1'b1;
   end

   assign count = count_q;

   for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
      logic flag_q;
      logic hit;
      assign hit = (count_q == limits[i*CNT_W +: CNT_W]);
      always_ff @(posedge clk or negedge arst_n) begin
         if (!arst_n)                    flag_q <= 1'b0;
         else if (ctl.restart | ctl.clr) flag_q <= 1'b0;
         else if (hit)                   flag_q <= 1'b1;
      end
      assign flags[i] = flag_q;
   end
endmodule

// File: rtl/blank_mux.sv
module blank_mux #(
   parameter int unsigned NUM_CH = 4,
   parameter int unsigned DATA_W = 13
) (
   input  logic                      clk,
   input  logic                      arst_n,
   input  blank_pkg::blank_ctl_t     ctl,
   input  logic [NUM_CH*DATA_W-1:0]  din,
   input  logic [NUM_CH*DATA_W-1:0]  levels,
   output logic [NUM_CH*DATA_W-1:0]  din_q,
   output logic [NUM_CH*DATA_W-1:0]  dout
);
   if (NUM_CH < 1) begin : g_bad_ch
      $error("blank_mux: NUM_CH must be at least 1");
   end
   if (DATA_W < 1) begin : g_bad_w
      $error("blank_mux: DATA_W must be at least 1");
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
      logic [DATA_W-1:0] in_q;
      logic [DATA_W-1:0] out_q;

      always_ff @(posedge clk or negedge arst_n) begin
         if (!arst_n) begin
            in_q  <= '0;
            out_q <= '0;
         end else begin
            in_q  <= din[c*DATA_W +: DATA_W];
            out_q <= ctl.blank ? levels[c*DATA_W +: DATA_W] : in_q;
         end
      end

      assign din_q[c*DATA_W +: DATA_W] = in_q;
      assign dout[c*DATA_W +: DATA_W]  = out_q;
   end
endmodule

// File: rtl/blank_level_unit.sv
module blank_level_unit #(
   parameter int unsigned NUM_CH    = 4,
   parameter int unsigned DATA_W    = 13,
   parameter int unsigned NUM_FLAGS = 2,
   parameter int unsigned CNT_W     = 20,
   localparam int unsigned ADDR_W   = blank_pkg::addr_bits(NUM_CH + NUM_FLAGS),
   localparam int unsigned WR_W     = blank_pkg::width_max(DATA_W, CNT_W)
) (
   input  logic                       clk,
   input  logic                       arst_n,
   input  logic                       clr_n,
   input  logic                       hblank,
   input  logic [NUM_CH*DATA_W-1:0]   din,
   input  logic                       wr_en,
   input  logic [ADDR_W-1:0]          wr_addr,
   input  logic [WR_W-1:0]            wr_data,
   output logic [NUM_CH*DATA_W-1:0]   dout,
   output logic [NUM_FLAGS-1:0]       flags
);
   blank_pkg::blank_ctl_t          ctl;
   logic [NUM_CH*DATA_W-1:0]       levels;
   logic [NUM_FLAGS*CNT_W-1:0]     limits;
   logic [NUM_CH*DATA_W-1:0]       din_q;
   logic [CNT_W-1:0]               count;

   blank_sampler u_sampler (
      .clk    (clk),
      .arst_n (arst_n),
      .hblank (hblank),
      .clr_n  (clr_n),
      .ctl    (ctl)
   );

   blank_regs #(
      .NUM_CH    (NUM_CH),
      .DATA_W    (DATA_W),
      .NUM_FLAGS (NUM_FLAGS),
      .CNT_W     (CNT_W),
      .ADDR_W    (ADDR_W),
      .WR_W      (WR_W)
   ) u_regs (
      .clk     (clk),
      .arst_n  (arst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .levels  (levels),
      .limits  (limits)
   );

   blank_counter #(
      .CNT_W     (CNT_W),
      .NUM_FLAGS (NUM_FLAGS)
   ) u_counter (
      .clk    (clk),
      .arst_n (arst_n),
      .ctl    (ctl),
      .limits (limits),
      .count  (count),
      .flags  (flags)
   );

   blank_mux #(
      .NUM_CH (NUM_CH),
      .DATA_W (DATA_W)
   ) u_mux (
      .clk    (clk),
      .arst_n (arst_n),
      .ctl    (ctl),
      .din    (din),
      .levels (levels),
      .din_q  (din_q),
      .dout   (dout)
   );
endmodule

// File: rtl/blank_level_unit_chk.sv
module blank_level_unit_chk #(
   parameter int unsigned NUM_CH    = 4,
   parameter int unsigned DATA_W    = 13,
   parameter int unsigned NUM_FLAGS = 2,
   parameter int unsigned CNT_W     = 20
) (
   input logic                        clk,
   input logic                        arst_n,
   input blank_pkg::blank_ctl_t       ctl,
   input logic [CNT_W-1:0]            count,
   input logic [NUM_FLAGS*CNT_W-1:0]  limits,
   input logic [NUM_CH*DATA_W-1:0]    levels,
   input logic [NUM_CH*DATA_W-1:0]    din_q,
   input logic [NUM_CH*DATA_W-1:0]    dout,
   input logic [NUM_FLAGS-1:0]        flags
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   // R2: restart forces the counter to zero
   assert_restart_zero_R2: assert property (@(posedge clk) disable iff (!arst_n)
      ctl.restart |=> (count == '0));

   // R2: counter steps by one when not restarting and not saturated
   assert_count_step_R2: assert property (@(posedge clk) disable iff (!arst_n)
      (!ctl.restart && count != CNT_MAX) |=> (count == CNT_W'($past(count) + 1'b1)));

   // R7: saturated counter holds
   assert_no_wrap_R7: assert property (@(posedge clk) disable iff (!arst_n)
      (!ctl.restart && count == CNT_MAX) |=> (count == CNT_MAX));

   // R5: restart empties all flags
   assert_restart_clears_R5: assert property (@(posedge clk) disable iff (!arst_n)
      ctl.restart |=> (flags == '0));

   // R6: registered clear empties all flags
   assert_clear_R6: assert property (@(posedge clk) disable iff (!arst_n)
      ctl.clr |=> (flags == '0));

   for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag_chk
      // R3: a flag sets when the counter meets its own limit
      assert_flag_set_R3: assert property (@(posedge clk) disable iff (!arst_n)
         (!ctl.restart && !ctl.clr && count == limits[i*CNT_W +: CNT_W]) |=> flags[i]);

      // R4: a set flag stays set without restart or clear
      assert_flag_sticky_R4: assert property (@(posedge clk) disable iff (!arst_n)
         (!ctl.restart && !ctl.clr && flags[i]) |=> flags[i]);
   end

   // R8: blanked output carries the programmed levels
   assert_blank_level_R8: assert property (@(posedge clk) disable iff (!arst_n)
      ctl.blank |=> (dout == $past(levels)));

   // R9: live output carries the registered input
   assert_live_data_R9: assert property (@(posedge clk) disable iff (!arst_n)
      !ctl.blank |=> (dout == $past(din_q)));

   // R1: outputs are cleared while reset is held
   always_comb begin
      if (!arst_n) begin
         assert_reset_out_R1: assert (dout == '0 && flags == '0);
      end
   end
endmodule

bind blank_level_unit blank_level_unit_chk #(
   .NUM_CH    (NUM_CH),
   .DATA_W    (DATA_W),
   .NUM_FLAGS (NUM_FLAGS),
   .CNT_W     (CNT_W)
) u_chk (
   .clk    (clk),
   .arst_n (arst_n),
   .ctl    (ctl),
   .count  (count),
   .limits (limits),
   .levels (levels),
   .din_q  (din_q),
   .dout   (dout),
   .flags  (flags)
);

// File: tb/test_blank_level_unit.sv
`timescale 1ns/1ps
module test_blank_level_unit;
   localparam int NCH  = 4;
   localparam int DW   = 13;
   localparam int NFL  = 2;
   localparam int CW   = 8;
   localparam int AW   = 3;
   localparam int WW   = 13;
   localparam int CMAX = (1 << CW) - 1;

   logic              clk = 1'b0;
   logic              arst_n = 1'b0;
   logic              clr_n = 1'b1;
   logic              hblank = 1'b0;
   logic [NCH*DW-1:0] din = '0;
   logic              wr_en = 1'b0;
   logic [AW-1:0]     wr_addr = '0;
   logic [WW-1:0]     wr_data = '0;
   logic [NCH*DW-1:0] dout;
   logic [NFL-1:0]    flags;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   always #5 clk = ~clk;

   blank_level_unit #(.NUM_CH(NCH), .DATA_W(DW), .NUM_FLAGS(NFL), .CNT_W(CW)) i_blank_level_unit (
      .clk(clk), .arst_n(arst_n), .clr_n(clr_n), .hblank(hblank), .din(din),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .dout(dout), .flags(flags));

   // Behavioural reference, updated on every clock from the requirements.
   int m_hb, m_hb_prev, m_clr, m_cnt;
   int m_flag [NFL];
   int m_tc   [NFL];
   int m_lvl  [NCH];
   int m_inq  [NCH];
   int m_out  [NCH];

   always @(posedge clk or negedge arst_n) begin
      if (!arst_n) begin
         m_hb = 0; m_hb_prev = 0; m_clr = 0; m_cnt = 0;
         for (int i = 0; i < NFL; i++) begin m_flag[i] = 0; m_tc[i] = CMAX; end
         for (int c = 0; c < NCH; c++) begin m_lvl[c] = 0; m_inq[c] = 0; m_out[c] = 0; end
      end else begin
         int restart;
         restart = (m_hb_prev == 1 && m_hb == 0);
         for (int i = 0; i < NFL; i++) begin
            if (restart || m_clr) m_flag[i] = 0;
            else if (m_cnt == m_tc[i]) m_flag[i] = 1;
         end
         for (int c = 0; c < NCH; c++) begin
            m_out[c] = m_hb ? m_lvl[c] : m_inq[c];
            m_inq[c] = int'(din[c*DW +: DW]);
         end
         if (restart) m_cnt = 0;
         else if (m_cnt < CMAX) m_cnt = m_cnt + 1;
         if (wr_en) begin
            if (int'(wr_addr) < NCH) m_lvl[int'(wr_addr)] = int'(wr_data[DW-1:0]);
            else if (int'(wr_addr) < NCH + NFL) m_tc[int'(wr_addr) - NCH] = int'(wr_data[CW-1:0]);
         end
         m_hb_prev = m_hb;
         m_hb  = int'(hblank);
         m_clr = int'(!clr_n);
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      n_tests++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      int mf;
      mf = 0;
      for (int i = 0; i < NFL; i++) mf |= (m_flag[i] << i);
      chk("R2/R3 flags vs model", int'(flags), mf);
      for (int c = 0; c < NCH; c++)
         chk("R8/R9 dout vs model", int'(dout[c*DW +: DW]), m_out[c]);
   endtask

   task automatic step(input int n = 1);
      for (int k = 0; k < n; k++) begin
         @(posedge clk);
         @(negedge clk);
         compare_all();
      end
   endtask

   task automatic wr(input int addr, input int data);
      wr_en = 1'b1; wr_addr = AW'(addr); wr_data = WW'(data);
      step();
      wr_en = 1'b0;
   endtask

   localparam int LV [NCH] = '{13'h0AA, 13'h1555, 13'h1F0F, 13'h000F};

   initial begin
      // R1: reset state
      repeat (3) @(negedge clk);
      chk("R1 dout in reset", int'(dout), 0);
      chk("R1 flags in reset", int'(flags), 0);
      arst_n = 1'b1;
      step();
      chk("R1 dout after release", int'(dout), 0);
      chk("R1 flags after release", int'(flags), 0);

      // R11/R10: program levels and terminal counts
      for (int c = 0; c < NCH; c++) wr(c, LV[c]);
      wr(NCH + 0, 3);
      wr(NCH + 1, 5);

      // R8: blanking replaces every channel
      hblank = 1'b1;
      din = {13'h0123, 13'h0456, 13'h0789, 13'h0ABC};
      step(3);
      for (int c = 0; c < NCH; c++)
         chk("R8 blank level", int'(dout[c*DW +: DW]), LV[c]);

      // R2/R3/R9: falling edge of blanking
      hblank = 1'b0;
      din = {13'h1111, 13'h0222, 13'h0333, 13'h0444};
      step(2);
      chk("R9 live data ch0", int'(dout[0 +: DW]), 13'h0444);
      chk("R9 live data ch3", int'(dout[3*DW +: DW]), 13'h1111);
      chk("R5 flags cleared by restart", int'(flags), 0);
      step(3);
      chk("R2 flag0 not yet", int'(flags), 0);
      step();
      chk("R2 flag0 at T=3", int'(flags), 1);
      step();
      chk("R3 flag1 independent", int'(flags), 1);
      step();
      chk("R3 flag1 at T=5", int'(flags), 3);

      // R4: sticky
      step(20);
      chk("R4 flags sticky", int'(flags), 3);

      // R5: second restart with flags set
      hblank = 1'b1;
      step(3);
      hblank = 1'b0;
      step(2);
      chk("R5 restart clears set flags", int'(flags), 0);
      step(10);
      chk("R3 both flags again", int'(flags), 3);

      // R6: registered clear
      clr_n = 1'b0;
      step();
      clr_n = 1'b1;
      chk("R6 clear not yet", int'(flags), 3);
      step();
      chk("R6 clear applied", int'(flags), 0);

      // R7: saturation
      wr(NCH + 0, CMAX - 1);
      wr(NCH + 1, CMAX);
      hblank = 1'b1; step(2);
      hblank = 1'b0; step(CMAX + 20);
      chk("R7 both flags after saturation", int'(flags), 3);
      clr_n = 1'b0; step();
      clr_n = 1'b1; step();
      chk("R7 cleared", int'(flags), 0);
      step();
      chk("R7 max flag re-sets, no wrap", int'(flags), 2);

      // R10: unmapped address ignored
      wr(NCH + NFL, 13'h1ABC);
      wr(7, 13'h0FFF);
      hblank = 1'b1;
      step(3);
      for (int c = 0; c < NCH; c++)
         chk("R10 levels untouched by unmapped write", int'(dout[c*DW +: DW]), LV[c]);
      wr(1, 13'h0777);
      step();
      chk("R10 new level in force", int'(dout[DW +: DW]), 13'h0777);

      // Mixed traffic against the model
      for (int k = 0; k < 600; k++) begin
         din = {$urandom, $urandom};
         if ($urandom_range(0, 9) == 0) hblank = ~hblank;
         clr_n = ($urandom_range(0, 40) != 0);
         if ($urandom_range(0, 15) == 0) begin
            wr_en = 1'b1; wr_addr = AW'($urandom_range(0, 7)); wr_data = WW'($urandom);
         end else wr_en = 1'b0;
         step();
      end
      wr_en = 1'b0;

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog (all R) actual=running expected=finished");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule